// File: doc/BRIEF.md
# Cone-wise exhaustive test pattern generator

This block feeds test stimulus to an eight-input logic circuit whose outputs each depend on only five of those inputs. The two groups of five inputs, called cones here, share two inputs. Exhaustive testing of all eight inputs would take 256 vectors. This block instead applies every one of the 32 combinations to the first cone and then every one of the 32 combinations to the second cone, for 64 vectors in all. Each cone still sees exhaustive stimulus on its own inputs.

Cone membership is fixed at build time by two bit masks, one per cone. Bit i of a mask is set when primary input i belongs to that cone. A five-bit count is spread onto the set bits of the active cone's mask. Inputs outside the active cone are driven low. A one-cycle start pulse launches a run. A strobe marks each of the 64 valid vectors, and a one-cycle completion pulse follows the last vector. The generator does not derive cones from a netlist and does not compact responses.

Top module: `cone_pg_top`

## Requirements
- R1: After reset, pat_valid and done are 0 and pattern is all zeros.
- R2: A start seen at a clock edge while idle makes pat_valid high from that edge on. The first vector is present in the same cycle.
- R3: pat_valid stays high for exactly 64 consecutive cycles in a run.
- R4: In the first 32 valid cycles, count c runs from 0 to 31 and cone A is active. Bit k of c drives the k-th lowest set bit of CONE_A_MASK. With the default mask 8'h1F, the pattern equals c.
- R5: In the next 32 valid cycles, count c runs from 0 to 31 again and cone B is active in the same way. With the default mask 8'hF8, the pattern equals c shifted left by 3. The shared inputs 3 and 4 therefore toggle in both phases.
- R6: done is high for exactly one cycle, in the cycle right after the last valid vector, and never together with pat_valid.
- R7: A start asserted during a run, including the done cycle, is ignored. The vector sequence and the done timing stay unchanged, and the block returns to idle after done.
- R8: pattern is all zeros in every cycle in which pat_valid is low.
- R9: After a run completes, a new start repeats the identical 64-vector sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a run when idle |
| pattern | output | 8 | Test vector for the primary inputs |
| pat_valid | output | 1 | High while pattern carries a test vector |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
A start request and the stepping of the vector sequence can land in the same cycle, and so can a start request and the completion pulse. The bench raises start on many cycles inside a run and again in the done cycle. It then checks that every vector still matches the arithmetically expected value, that done arrives 64 cycles after the real launch, and that pat_valid is low in the cycle after done. A clean restart after completion must reproduce the sequence exactly.

// File: rtl/cone_pg_pkg.sv
// Package: shared types and elaboration-time helpers for the cone
// pattern generator. Assumes masks are no wider than 32 bits.
package cone_pg_pkg;

    // Run-control states of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } run_state_t;

    // Number of set bits of a mask below bit position pos.
    function automatic int rank_below(input logic [31:0] mask, input int pos);
        int n;
        n = 0;
        for (int j = 0; j < 32; j++) begin
            if (j < pos && mask[j]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/cone_pg_seq.sv
// Module: run sequencer. Holds the run state and a combined index whose
// low CONE_W bits are the cone count and whose top bit selects the cone.
// Assumes start is synchronous to clk.
module cone_pg_seq
    import cone_pg_pkg::*;
#(
    parameter int CONE_W = 5,
    localparam int IDX_W = CONE_W + 1,
    localparam int TOTAL = 2 << CONE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [CONE_W-1:0] cnt,
    output logic              phase,
    output logic              running,
    output logic              finish
);

    run_state_t         state_q;
    logic [IDX_W-1:0]   idx_q;

    // Advance the run state and the vector index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (start) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (idx_q == IDX_W'(TOTAL - 1)) begin
                        state_q <= ST_FIN;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Expose the index fields and state flags.
    always_comb begin
        cnt     = idx_q[CONE_W-1:0];
        phase   = idx_q[IDX_W-1];
        running = (state_q == ST_RUN);
        finish  = (state_q == ST_FIN);
    end

endmodule

// File: rtl/cone_pg_scatter.sv
// Module: spreads a CONE_W-bit count onto the set bits of MASK in
// ascending order. Non-member bits are 0. Assumes MASK has CONE_W set bits.
module cone_pg_scatter
    import cone_pg_pkg::*;
#(
    parameter int          N_IN   = 8,
    parameter int          CONE_W = 5,
    parameter logic [31:0] MASK   = 32'h1F
) (
    input  logic [CONE_W-1:0] cnt,
    output logic [N_IN-1:0]   pat
);

    // One wire per primary input: member bits take their ranked count bit.
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
        localparam int RANK = rank_below(MASK, i);
        if (MASK[i] && RANK < CONE_W) begin : g_member
            assign pat[i] = cnt[RANK];
        end else begin : g_zero
            assign pat[i] = 1'b0;
        end
    end

endmodule

// File: rtl/cone_pg_top.sv
// Module: cone-wise exhaustive pattern generator top. It runs cone A's
// 2^CONE_W combinations and then cone B's. Outputs are zero when idle.
// Assumes each mask has exactly CONE_W set bits within N_IN.
module cone_pg_top #(
    parameter int          N_IN        = 8,
    parameter int          CONE_W      = 5,
    parameter logic [31:0] CONE_A_MASK = 32'h0000_001F,
    parameter logic [31:0] CONE_B_MASK = 32'h0000_00F8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [N_IN-1:0] pattern,
    output logic            pat_valid,
    output logic            done
);

    logic [CONE_W-1:0] cnt;
    logic              phase;
    logic              running;
    logic              finish;
    logic [N_IN-1:0]   pat_a;
    logic [N_IN-1:0]   pat_b;

    cone_pg_seq #(.CONE_W(CONE_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cnt     (cnt),
        .phase   (phase),
        .running (running),
        .finish  (finish)
    );

    cone_pg_scatter #(.N_IN(N_IN), .CONE_W(CONE_W), .MASK(CONE_A_MASK)) u_map_a (
        .cnt (cnt),
        .pat (pat_a)
    );

    cone_pg_scatter #(.N_IN(N_IN), .CONE_W(CONE_W), .MASK(CONE_B_MASK)) u_map_b (
        .cnt (cnt),
        .pat (pat_b)
    );

    // Select the active cone's vector and gate it with the run flag.
    always_comb begin
        pattern   = running ? (phase ? pat_b : pat_a) : '0;
        pat_valid = running;
        done      = finish;
    end

endmodule

// File: rtl/cone_pg_chk.sv
// Module: protocol checker for cone_pg_top, observing only its ports.
// It keeps its own count of valid cycles per run.
module cone_pg_chk #(
    parameter int          N_IN        = 8,
    parameter int          CONE_W      = 5,
    parameter logic [31:0] CONE_A_MASK = 32'h1F,
    parameter logic [31:0] CONE_B_MASK = 32'hF8,
    localparam int TOTAL = 2 << CONE_W,
    localparam int VC_W  = $clog2(TOTAL) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [N_IN-1:0] pattern,
    input logic            pat_valid,
    input logic            done
);

    logic [VC_W-1:0] vcnt;
    logic [N_IN-1:0] outside;

    assign outside = ~(CONE_A_MASK[N_IN-1:0] | CONE_B_MASK[N_IN-1:0]);

    // Count valid cycles of the current run; clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) vcnt <= '0;
        else if (done) vcnt <= '0;
        else if (pat_valid) vcnt <= vcnt + 1'b1;
    end

    assert_launch_by_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_valid) |-> $past(start));

    assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> (vcnt < VC_W'(TOTAL)));

    assert_run_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && vcnt < VC_W'(TOTAL - 1)) |=> pat_valid);

    assert_done_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && vcnt == VC_W'(TOTAL - 1)) |=> done);

    assert_done_after_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt == VC_W'(TOTAL)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_valid_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pat_valid && done));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_valid |-> (pattern == '0));

    assert_outside_cones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern & outside) == '0);

endmodule

bind cone_pg_top cone_pg_chk #(
    .N_IN        (N_IN),
    .CONE_W      (CONE_W),
    .CONE_A_MASK (CONE_A_MASK),
    .CONE_B_MASK (CONE_B_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pattern   (pattern),
    .pat_valid (pat_valid),
    .done      (done)
);

// File: tb/cone_pg_top_test.sv
module cone_pg_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] pattern;
    logic       pat_valid;
    logic       done;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    cone_pg_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pattern   (pattern),
        .pat_valid (pat_valid),
        .done      (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One run; mode 1 pokes start throughout the run and in the done cycle.
    task automatic run_seq(input int mode);
        logic [7:0] exp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 64; i++) begin
            // R4: cone A count equals pattern; R5: cone B count shifted by 3
            exp = (i < 32) ? 8'(i) : 8'((i - 32) << 3);
            chk("R2/R3 valid", {31'd0, pat_valid}, 32'd1);
            chk(i < 32 ? "R4 cone A vector" : "R5 cone B vector", {24'd0, pattern}, {24'd0, exp});
            chk("R6 no done in run", {31'd0, done}, 32'd0);
            start = (mode == 1) && (i % 3 != 1);  // R7 start during run
            @(negedge clk);
        end
        start = 1'b0;
        chk("R6 done pulse", {31'd0, done}, 32'd1);
        chk("R6 valid low at done", {31'd0, pat_valid}, 32'd0);
        chk("R8 zero at done", {24'd0, pattern}, 32'd0);
        if (mode == 1) start = 1'b1;          // R7 start in done cycle
        @(negedge clk);
        start = 1'b0;
        chk("R6 done single", {31'd0, done}, 32'd0);
        chk("R7 idle after done", {31'd0, pat_valid}, 32'd0);
        chk("R8 zero idle", {24'd0, pattern}, 32'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R7 stays idle", {31'd0, pat_valid}, 32'd0);
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        start = 1'b1;  // R1 reset dominates start
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, pat_valid}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 pattern", {24'd0, pattern}, 32'd0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {31'd0, pat_valid}, 32'd0);
        run_seq(0);
        run_seq(1);   // R7
        run_seq(0);   // R9 identical repeat
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule